// File: doc/BRIEF.md
# Multithreaded Dispatch Stage with Skid Buffer

This block is the dispatch controller of an out-of-order core, placed between the rename stage and the issue-side queues. Each cycle rename presents a group of up to `W` renamed instructions, all belonging to one hardware thread. Each instruction carries a class code, a "squashed" marker and an opaque tag. Every thread has its own five-state control machine: Idle, Running, Blocked, Unblocking and Squashing. Every thread also has its own skid buffer, which catches instructions that cannot be dispatched in the cycle they arrive.

For every thread the block drives `W` registered dispatch lanes. Each lane carries a route bitmap that selects the issue queue, the non-speculative list, the barrier path, the load queue, the store queue, or immediate completion. Back towards rename it drives one-cycle block and unblock pulses and per-cycle credit counts for every instruction removed from the stage. An instruction counts as removed whether it was dispatched, dropped as squashed, or discarded by a flush. The occupancy of the issue, load and store queues arrives as simple full flags, one set per thread. A squash from commit and the "reorder buffer still squashing" flag also arrive per thread.

Top module: `dsp_stage`

## Requirements
- R1: Each dispatched lane shows a route bitmap with these bits: bit0 issue queue, bit1 non-speculative list, bit2 barrier path, bit3 load queue, bit4 store queue, bit5 completed at dispatch. The bitmap depends on the class code (`grp_kind`). Class 0 (plain) sets bit0. Class 1 (load) sets bit0 and bit3. Class 2 (store) sets bit0 and bit4. Class 3 (store-conditional) sets bit1 and bit4. Class 4 (non-speculative) sets bit1. Class 5 (barrier) sets bit2. Class 6 (nop) sets bit5. The lane tag equals the instruction tag. Lane i carries the i-th instruction taken that cycle, in program order.
- R2: After reset every lane, every pulse, every credit and every overflow flag is low, and all threads are Idle. The first group that a thread accepts is dispatched in the same way as in Running.
- R3: Every instruction removed from the stage in a cycle adds one to `cred_disp`. Every removed load adds one to `cred_lq`. Every removed store or store-conditional adds one to `cred_sq`. Credits appear one cycle after the removal and last for one cycle.
- R4: An instruction marked squashed uses a dispatch slot and returns its credits, but its lane stays invalid.
- R5: Dispatch stops at the first load that meets a full load queue, or at the first store or store-conditional that meets a full store queue. That instruction and all younger ones in the group go to the skid buffer, and the thread becomes Blocked.
- R6: While the issue queue of a thread is full, that thread dispatches nothing, pushes its whole incoming group into its skid buffer and is Blocked.
- R7: `ren_block` pulses for one cycle only when a thread enters Blocked from a state other than Blocked or Unblocking.
- R8: When its stall clears, a Blocked thread dispatches from its skid buffer first, at most `W` entries per cycle, oldest first. New groups that arrive meanwhile are appended behind the skid entries. When the skid buffer empties, `ren_unblock` pulses and the thread returns to Running.
- R9: A squash from commit empties the skid buffer and the incoming group, with credits for all of them, and moves the thread to Squashing. `ren_unblock` pulses if the thread was Blocked or Unblocking at that moment.
- R10: While the reorder buffer is squashing, the incoming group is discarded with credits. The first cycle without a squash indication returns the thread to Running and dispatches that cycle's group.
- R11: A push beyond the skid depth drops the excess instructions and sets `skid_ovf` for that thread. The flag stays set until reset.
- R12: A group affects only the thread named by `grp_tid`. The outputs of every other thread are not disturbed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_n | input | CW | Number of valid instructions in the group, packed from slot 0 |
| grp_tid | input | TID_W | Thread that owns the group |
| grp_kind | input | W x 3 | Class code per slot |
| grp_squashed | input | W | Squashed marker per slot |
| grp_tag | input | W x TAG_W | Opaque tag per slot |
| cmt_squash | input | NTHR | Squash from commit, per thread |
| rob_squashing | input | NTHR | Reorder buffer still squashing, per thread |
| iq_full | input | NTHR | Issue queue full, per thread |
| lq_full | input | NTHR | Load queue full, per thread |
| sq_full | input | NTHR | Store queue full, per thread |
| out_vld | output | NTHR x W | Lane valid |
| out_route | output | NTHR x W x 6 | Lane route bitmap |
| out_tag | output | NTHR x W x TAG_W | Lane tag |
| ren_block | output | NTHR | Block pulse to rename |
| ren_unblock | output | NTHR | Unblock pulse to rename |
| cred_disp | output | NTHR x CRW | Instructions removed this cycle |
| cred_lq | output | NTHR x CRW | Loads removed this cycle |
| cred_sq | output | NTHR x CRW | Stores removed this cycle |
| skid_ovf | output | NTHR | Sticky skid overflow flag |

## Verification
The hardest situation to reach is an Unblocking thread whose skid buffer holds more entries than one cycle can drain. That thread must fall back to Blocked without a new block pulse, and it must then finish the drain with a single unblock pulse. The stimulus gets there by stopping a full group on a load-queue-full slot, then adding one more instruction under an issue-queue stall so that three entries wait in a two-wide stage. A second hard case is a commit squash of a full, overflowed skid buffer. It is reached by stalling another thread for three groups in a row, and the bench then checks the summed load and store credits of the discarded entries.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam logic [2:0] K_ALU     = 3'd0;
  localparam logic [2:0] K_LOAD    = 3'd1;
  localparam logic [2:0] K_STORE   = 3'd2;
  localparam logic [2:0] K_STCOND  = 3'd3;
  localparam logic [2:0] K_NONSPEC = 3'd4;
  localparam logic [2:0] K_BARRIER = 3'd5;
  localparam logic [2:0] K_NOP     = 3'd6;

  localparam int ROUTE_W = 6;
  localparam int RB_IQ   = 0;
  localparam int RB_NS   = 1;
  localparam int RB_BAR  = 2;
  localparam int RB_LQ   = 3;
  localparam int RB_SQ   = 4;
  localparam int RB_DONE = 5;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_RUN  = 3'd1,
    TS_BLK  = 3'd2,
    TS_UNB  = 3'd3,
    TS_SQU  = 3'd4
  } tstate_e;

  function automatic logic is_ld(input logic [2:0] k);
    return k == K_LOAD;
  endfunction

  function automatic logic is_st(input logic [2:0] k);
    return (k == K_STORE) || (k == K_STCOND);
  endfunction
endpackage

// File: rtl/dsp_route.sv
module dsp_route
  import dsp_pkg::*;
(
  input  logic [2:0]         kind,
  output logic [ROUTE_W-1:0] route
);
  always_comb begin
    route = '0;
    case (kind)
      K_LOAD:    begin route[RB_IQ] = 1'b1; route[RB_LQ] = 1'b1; end
      K_STORE:   begin route[RB_IQ] = 1'b1; route[RB_SQ] = 1'b1; end
      K_STCOND:  begin route[RB_NS] = 1'b1; route[RB_SQ] = 1'b1; end
      K_NONSPEC: route[RB_NS]   = 1'b1;
      K_BARRIER: route[RB_BAR]  = 1'b1;
      K_NOP:     route[RB_DONE] = 1'b1;
      default:   route[RB_IQ]   = 1'b1;
    endcase
    AST_ROUTE_ONE: assert ($onehot({route[RB_IQ], route[RB_NS], route[RB_BAR], route[RB_DONE]})); // R1
  end
endmodule

// File: rtl/dsp_skid.sv
module dsp_skid
  import dsp_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  localparam int CW    = $clog2(W + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic [CW-1:0]             push_n,
  input  logic [W-1:0][2:0]         push_kind,
  input  logic [W-1:0]              push_sq,
  input  logic [W-1:0][TAG_W-1:0]   push_tag,
  input  logic [CW-1:0]             pop_n,
  output logic [W-1:0][2:0]         head_kind,
  output logic [W-1:0]              head_sq,
  output logic [W-1:0][TAG_W-1:0]   head_tag,
  output logic [CNT_W-1:0]          cnt,
  output logic [CNT_W-1:0]          ld_cnt,
  output logic [CNT_W-1:0]          st_cnt,
  output logic                      ovf
);
  logic [2:0]       mem_kind [DEPTH];
  logic             mem_sq   [DEPTH];
  logic [TAG_W-1:0] mem_tag  [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  int               free_i, acc_i;
  logic             over;

  always_comb begin
    free_i = DEPTH - int'(cnt_q) + int'(pop_n);
    over   = int'(push_n) > free_i;
    acc_i  = over ? free_i : int'(push_n);
  end

  for (genvar i = 0; i < W; i++) begin : g_head
    assign head_kind[i] = mem_kind[rd_q + PTR_W'(i)];
    assign head_sq[i]   = mem_sq[rd_q + PTR_W'(i)];
    assign head_tag[i]  = mem_tag[rd_q + PTR_W'(i)];
  end

  always_comb begin
    int nl, ns;
    nl = 0;
    ns = 0;
    for (int j = 0; j < DEPTH; j++) begin
      if (int'(PTR_W'(PTR_W'(j) - rd_q)) < int'(cnt_q)) begin
        if (is_ld(mem_kind[j])) nl++;
        if (is_st(mem_kind[j])) ns++;
      end
    end
    ld_cnt = CNT_W'(nl);
    st_cnt = CNT_W'(ns);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < W; k++) begin
      if (!flush && k < acc_i) begin
        mem_kind[wr_q + PTR_W'(k)] <= push_kind[k];
        mem_sq[wr_q + PTR_W'(k)]   <= push_sq[k];
        mem_tag[wr_q + PTR_W'(k)]  <= push_tag[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush) begin
      rd_q  <= wr_q;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_q + PTR_W'(pop_n);
      wr_q  <= wr_q + PTR_W'(acc_i);
      cnt_q <= CNT_W'(int'(cnt_q) - int'(pop_n) + acc_i);
      if (over) ovf_q <= 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_q |=> ovf_q); // R11
endmodule

// File: rtl/dsp_thread.sv
module dsp_thread
  import dsp_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  localparam int CW    = $clog2(W + 1),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CRW   = $clog2(DEPTH + W + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [CW-1:0]                     in_n,
  input  logic [W-1:0][2:0]                 in_kind,
  input  logic [W-1:0]                      in_sq,
  input  logic [W-1:0][TAG_W-1:0]           in_tag,
  input  logic                              squash,
  input  logic                              rob_sq,
  input  logic                              iq_full,
  input  logic                              lq_full,
  input  logic                              sq_full,
  output logic [W-1:0]                      lane_vld,
  output logic [W-1:0][ROUTE_W-1:0]         lane_route,
  output logic [W-1:0][TAG_W-1:0]           lane_tag,
  output logic                              blk,
  output logic                              unblk,
  output logic [CRW-1:0]                    cr_disp,
  output logic [CRW-1:0]                    cr_lq,
  output logic [CRW-1:0]                    cr_sq,
  output logic                              ovf
);
  tstate_e st_q, nxt, eff;

  logic                      flush;
  logic [CW-1:0]             push_n, pop_n;
  logic [W-1:0][2:0]         push_kind, head_kind, src_kind;
  logic [W-1:0]              push_sq, head_sq, src_sq;
  logic [W-1:0][TAG_W-1:0]   push_tag, head_tag, src_tag;
  logic [W-1:0][ROUTE_W-1:0] src_route;
  logic [CNT_W-1:0]          sk_cnt, sk_ld, sk_st;

  logic [W-1:0]              vld_d;
  logic [W-1:0][ROUTE_W-1:0] route_d;
  logic [W-1:0][TAG_W-1:0]   tag_d;
  logic                      blk_d, unb_d;
  int                        cd, cl, cs, in_ld, in_st;

  dsp_skid #(.W(W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_skid (
    .clk(clk), .rst(rst), .flush(flush),
    .push_n(push_n), .push_kind(push_kind), .push_sq(push_sq), .push_tag(push_tag),
    .pop_n(pop_n),
    .head_kind(head_kind), .head_sq(head_sq), .head_tag(head_tag),
    .cnt(sk_cnt), .ld_cnt(sk_ld), .st_cnt(sk_st), .ovf(ovf)
  );

  // Draining threads take their oldest entries from the skid buffer.
  always_comb begin
    logic from_skid;
    from_skid = (st_q == TS_BLK) || (st_q == TS_UNB);
    src_kind  = from_skid ? head_kind : in_kind;
    src_sq    = from_skid ? head_sq   : in_sq;
    src_tag   = from_skid ? head_tag  : in_tag;
  end

  for (genvar i = 0; i < W; i++) begin : g_route
    dsp_route u_route (.kind(src_kind[i]), .route(src_route[i]));
  end

  always_comb begin
    in_ld = 0;
    in_st = 0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(in_n)) begin
        if (is_ld(in_kind[i])) in_ld++;
        if (is_st(in_kind[i])) in_st++;
      end
    end
  end

  always_comb begin
    int avail, take, left, pb, pn;
    logic stop;
    nxt = st_q; eff = st_q;
    blk_d = 1'b0; unb_d = 1'b0;
    cd = 0; cl = 0; cs = 0;
    vld_d = '0; route_d = '0; tag_d = '0;
    flush = 1'b0; pop_n = '0;
    avail = 0; take = 0; left = 0; pb = 0; pn = 0; stop = 1'b0;
    if (squash) begin
      flush = 1'b1;
      nxt   = TS_SQU;
      unb_d = (st_q == TS_BLK) || (st_q == TS_UNB);
      cd = int'(sk_cnt) + int'(in_n);
      cl = int'(sk_ld) + in_ld;
      cs = int'(sk_st) + in_st;
    end else if (rob_sq) begin
      nxt = TS_SQU;
      cd = int'(in_n); cl = in_ld; cs = in_st;
    end else if (iq_full) begin
      nxt   = TS_BLK;
      blk_d = (st_q != TS_BLK) && (st_q != TS_UNB);
      pn    = int'(in_n);
    end else begin
      case (st_q)
        TS_BLK:  eff = TS_UNB;
        TS_SQU:  eff = TS_RUN;
        default: eff = st_q;
      endcase
      avail = (eff == TS_UNB) ? int'(sk_cnt) : int'(in_n);
      for (int i = 0; i < W; i++) begin
        if (i < avail && !stop) begin
          if (!src_sq[i] && ((is_ld(src_kind[i]) && lq_full) || (is_st(src_kind[i]) && sq_full))) begin
            stop = 1'b1;
          end else begin
            take++;
            cd++;
            if (is_ld(src_kind[i])) cl++;
            if (is_st(src_kind[i])) cs++;
            if (!src_sq[i]) begin
              vld_d[i]   = 1'b1;
              route_d[i] = src_route[i];
              tag_d[i]   = src_tag[i];
            end
          end
        end
      end
      left = avail - take;
      if (eff == TS_UNB) begin
        pop_n = CW'(take);
        pn    = int'(in_n);
        if (left > 0) nxt = TS_BLK;
        else if (int'(sk_cnt) - take + int'(in_n) == 0) begin
          unb_d = 1'b1;
          nxt   = TS_RUN;
        end else nxt = TS_UNB;
      end else begin
        pb = take;
        pn = int'(in_n) - take;
        if (left > 0) begin
          nxt   = TS_BLK;
          blk_d = 1'b1;
        end else if (eff == TS_IDLE && take > 0) nxt = TS_RUN;
        else nxt = eff;
      end
    end
    push_n = CW'(pn);
    push_kind = '0; push_sq = '0; push_tag = '0;
    for (int k = 0; k < W; k++) begin
      if (pb + k < W) begin
        push_kind[k] = in_kind[pb + k];
        push_sq[k]   = in_sq[pb + k];
        push_tag[k]  = in_tag[pb + k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= TS_IDLE;
      lane_vld   <= '0;
      lane_route <= '0;
      lane_tag   <= '0;
      blk        <= 1'b0;
      unblk      <= 1'b0;
      cr_disp    <= '0;
      cr_lq      <= '0;
      cr_sq      <= '0;
    end else begin
      st_q       <= nxt;
      lane_vld   <= vld_d;
      lane_route <= route_d;
      lane_tag   <= tag_d;
      blk        <= blk_d;
      unblk      <= unb_d;
      cr_disp    <= CRW'(cd);
      cr_lq      <= CRW'(cl);
      cr_sq      <= CRW'(cs);
    end
  end

  AST_BLK_ONCE: assert property (@(posedge clk) disable iff (rst) blk |=> !blk); // R7
  AST_BLK_UNB_EXCL: assert property (@(posedge clk) disable iff (rst) !(blk && unblk)); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (iq_full && !squash && !rob_sq) |=> (lane_vld == '0)); // R6
  AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (rst) squash |=> (sk_cnt == '0)); // R9
  AST_CRED_COVERS: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_vld) <= int'(cr_disp)); // R3
endmodule

// File: rtl/dsp_stage.sv
module dsp_stage
  import dsp_pkg::*;
#(
  parameter int NTHR  = 2,
  parameter int W     = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  localparam int CW    = $clog2(W + 1),
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CRW   = $clog2(DEPTH + W + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [CW-1:0]                         grp_n,
  input  logic [TID_W-1:0]                      grp_tid,
  input  logic [W-1:0][2:0]                     grp_kind,
  input  logic [W-1:0]                          grp_squashed,
  input  logic [W-1:0][TAG_W-1:0]               grp_tag,
  input  logic [NTHR-1:0]                       cmt_squash,
  input  logic [NTHR-1:0]                       rob_squashing,
  input  logic [NTHR-1:0]                       iq_full,
  input  logic [NTHR-1:0]                       lq_full,
  input  logic [NTHR-1:0]                       sq_full,
  output logic [NTHR-1:0][W-1:0]                out_vld,
  output logic [NTHR-1:0][W-1:0][ROUTE_W-1:0]   out_route,
  output logic [NTHR-1:0][W-1:0][TAG_W-1:0]     out_tag,
  output logic [NTHR-1:0]                       ren_block,
  output logic [NTHR-1:0]                       ren_unblock,
  output logic [NTHR-1:0][CRW-1:0]              cred_disp,
  output logic [NTHR-1:0][CRW-1:0]              cred_lq,
  output logic [NTHR-1:0][CRW-1:0]              cred_sq,
  output logic [NTHR-1:0]                       skid_ovf
);
  initial begin
    AST_DEPTH_OK: assert (DEPTH >= W && (DEPTH & (DEPTH - 1)) == 0); // R11
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CW-1:0] own_n;
    assign own_n = (grp_tid == TID_W'(t)) ? grp_n : '0;

    dsp_thread #(.W(W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_thr (
      .clk(clk), .rst(rst),
      .in_n(own_n), .in_kind(grp_kind), .in_sq(grp_squashed), .in_tag(grp_tag),
      .squash(cmt_squash[t]), .rob_sq(rob_squashing[t]),
      .iq_full(iq_full[t]), .lq_full(lq_full[t]), .sq_full(sq_full[t]),
      .lane_vld(out_vld[t]), .lane_route(out_route[t]), .lane_tag(out_tag[t]),
      .blk(ren_block[t]), .unblk(ren_unblock[t]),
      .cr_disp(cred_disp[t]), .cr_lq(cred_lq[t]), .cr_sq(cred_sq[t]),
      .ovf(skid_ovf[t])
    );
  end
endmodule

// File: tb/dsp_stage_tb.sv
`timescale 1ns/1ps
module dsp_stage_tb;
  localparam int NTHR = 2, W = 2, DEPTH = 4, TAG_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] grp_n;
  logic [0:0] grp_tid;
  logic [W-1:0][2:0] grp_kind;
  logic [W-1:0] grp_squashed;
  logic [W-1:0][TAG_W-1:0] grp_tag;
  logic [NTHR-1:0] cmt_squash, rob_squashing, iq_full, lq_full, sq_full;
  logic [NTHR-1:0][W-1:0] out_vld;
  logic [NTHR-1:0][W-1:0][5:0] out_route;
  logic [NTHR-1:0][W-1:0][TAG_W-1:0] out_tag;
  logic [NTHR-1:0] ren_block, ren_unblock, skid_ovf;
  logic [NTHR-1:0][2:0] cred_disp, cred_lq, cred_sq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsp_stage #(.NTHR(NTHR), .W(W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .grp_n(grp_n), .grp_tid(grp_tid), .grp_kind(grp_kind),
    .grp_squashed(grp_squashed), .grp_tag(grp_tag), .cmt_squash(cmt_squash),
    .rob_squashing(rob_squashing), .iq_full(iq_full), .lq_full(lq_full), .sq_full(sq_full),
    .out_vld(out_vld), .out_route(out_route), .out_tag(out_tag), .ren_block(ren_block),
    .ren_unblock(ren_unblock), .cred_disp(cred_disp), .cred_lq(cred_lq), .cred_sq(cred_sq),
    .skid_ovf(skid_ovf)
  );

  typedef struct packed {
    logic [1:0] n; logic [2:0] k0; logic [2:0] k1; logic s0; logic s1;
    logic [7:0] t0; logic [7:0] t1; logic lqf; logic sqf; logic iqf;
    logic [1:0] ev; logic [5:0] er0; logic [5:0] er1; logic [7:0] et0;
    logic eblk; logic eunb; logic [2:0] ecd; logic [2:0] ecl; logic [2:0] ecs;
  } vec_t;

  // Thread 0 sequence. Classes: 0 plain, 1 load, 2 store, 3 st-cond, 4 non-spec, 5 barrier, 6 nop.
  localparam vec_t VEC [9] = '{
    '{2'd2, 3'd0, 3'd1, 1'b0, 1'b0, 8'h10, 8'h11, 1'b0, 1'b0, 1'b0, 2'b11, 6'h01, 6'h09, 8'h10, 1'b0, 1'b0, 3'd2, 3'd1, 3'd0},
    '{2'd2, 3'd2, 3'd6, 1'b0, 1'b0, 8'h12, 8'h13, 1'b0, 1'b0, 1'b0, 2'b11, 6'h11, 6'h20, 8'h12, 1'b0, 1'b0, 3'd2, 3'd0, 3'd1},
    '{2'd2, 3'd3, 3'd5, 1'b0, 1'b0, 8'h14, 8'h15, 1'b0, 1'b0, 1'b0, 2'b11, 6'h12, 6'h04, 8'h14, 1'b0, 1'b0, 3'd2, 3'd0, 3'd1},
    '{2'd2, 3'd4, 3'd0, 1'b0, 1'b1, 8'h16, 8'h17, 1'b0, 1'b0, 1'b0, 2'b01, 6'h02, 6'h00, 8'h16, 1'b0, 1'b0, 3'd2, 3'd0, 3'd0},
    '{2'd2, 3'd1, 3'd0, 1'b0, 1'b0, 8'h18, 8'h19, 1'b1, 1'b0, 1'b0, 2'b00, 6'h00, 6'h00, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0},
    '{2'd1, 3'd0, 3'd0, 1'b0, 1'b0, 8'h1A, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 6'h00, 6'h00, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0},
    '{2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b11, 6'h09, 6'h01, 8'h18, 1'b0, 1'b0, 3'd2, 3'd1, 3'd0},
    '{2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 6'h01, 6'h00, 8'h1A, 1'b0, 1'b1, 3'd1, 3'd0, 3'd0},
    '{2'd1, 3'd0, 3'd0, 1'b0, 1'b0, 8'h1B, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 6'h01, 6'h00, 8'h1B, 1'b0, 1'b0, 3'd1, 3'd0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic idle_in();
    grp_n = 0; grp_tid = 0; grp_kind = '0; grp_squashed = '0; grp_tag = '0;
    cmt_squash = '0; rob_squashing = '0; iq_full = '0; lq_full = '0; sq_full = '0;
  endtask

  task automatic grp(input int tid, input int n, input logic [2:0] k0, input logic [2:0] k1,
                     input logic [7:0] t0, input logic [7:0] t1);
    grp_tid = 1'(tid); grp_n = 2'(n);
    grp_kind[0] = k0; grp_kind[1] = k1;
    grp_squashed = '0;
    grp_tag[0] = t0; grp_tag[1] = t1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    tick();
    // R2 reset state
    chk("R2 vld", 32'(out_vld), 0);
    chk("R2 block", 32'(ren_block), 0);
    chk("R2 unblock", 32'(ren_unblock), 0);
    chk("R2 ovf", 32'(skid_ovf), 0);
    chk("R2 credits", 32'({cred_disp, cred_lq, cred_sq}), 0);

    // Table-driven walk on thread 0
    for (int v = 0; v < 9; v++) begin
      @(negedge clk);
      idle_in();
      grp(0, VEC[v].n, VEC[v].k0, VEC[v].k1, VEC[v].t0, VEC[v].t1);
      grp_squashed[0] = VEC[v].s0; grp_squashed[1] = VEC[v].s1;
      lq_full[0] = VEC[v].lqf; sq_full[0] = VEC[v].sqf; iq_full[0] = VEC[v].iqf;
      tick();
      chk("R1 lanes", 32'(out_vld[0]), 32'(VEC[v].ev));
      if (VEC[v].ev[0]) begin
        chk("R1 route0", 32'(out_route[0][0]), 32'(VEC[v].er0));
        chk("R8 tag0", 32'(out_tag[0][0]), 32'(VEC[v].et0));
      end
      if (VEC[v].ev[1]) chk("R1 route1", 32'(out_route[0][1]), 32'(VEC[v].er1));
      chk("R7 block", 32'(ren_block[0]), 32'(VEC[v].eblk));
      chk("R8 unblock", 32'(ren_unblock[0]), 32'(VEC[v].eunb));
      chk("R3 disp", 32'(cred_disp[0]), 32'(VEC[v].ecd));
      chk("R3 lq", 32'(cred_lq[0]), 32'(VEC[v].ecl));
      chk("R3 sq", 32'(cred_sq[0]), 32'(VEC[v].ecs));
      chk("R12 other", 32'(out_vld[1]), 0);
    end

    // R6 / R7: thread 1 stalls, enters Blocked once
    @(negedge clk); idle_in(); grp(1, 2, 3'd1, 3'd2, 8'h21, 8'h22); iq_full[1] = 1; tick();
    chk("R7 first block", 32'(ren_block[1]), 1);
    chk("R6 no lanes", 32'(out_vld[1]), 0);
    chk("R12 thread0 quiet", 32'({out_vld[0], ren_block[0]}), 0);
    @(negedge clk); idle_in(); grp(1, 2, 3'd0, 3'd0, 8'h23, 8'h24); iq_full[1] = 1; tick();
    chk("R7 no second block", 32'(ren_block[1]), 0);
    chk("R11 no ovf yet", 32'(skid_ovf[1]), 0);
    @(negedge clk); idle_in(); grp(1, 1, 3'd0, 3'd0, 8'h25, 8'h00); iq_full[1] = 1; tick();
    chk("R11 ovf set", 32'(skid_ovf[1]), 1);
    chk("R11 thread0 ovf", 32'(skid_ovf[0]), 0);
    // R9 squash while blocked
    @(negedge clk); idle_in(); grp(1, 1, 3'd1, 3'd0, 8'h26, 8'h00); cmt_squash[1] = 1; tick();
    chk("R9 unblock", 32'(ren_unblock[1]), 1);
    chk("R9 disp", 32'(cred_disp[1]), 5);
    chk("R9 lq", 32'(cred_lq[1]), 2);
    chk("R9 sq", 32'(cred_sq[1]), 1);
    chk("R9 lanes", 32'(out_vld[1]), 0);
    // R10 rob squashing
    @(negedge clk); idle_in(); grp(1, 1, 3'd2, 3'd0, 8'h27, 8'h00); rob_squashing[1] = 1; tick();
    chk("R10 disp", 32'(cred_disp[1]), 1);
    chk("R10 sq", 32'(cred_sq[1]), 1);
    chk("R10 lanes", 32'(out_vld[1]), 0);
    chk("R10 unblock", 32'(ren_unblock[1]), 0);
    @(negedge clk); idle_in(); grp(1, 1, 3'd0, 3'd0, 8'h28, 8'h00); tick();
    chk("R10 resume", 32'(out_vld[1]), 1);
    chk("R10 tag", 32'(out_tag[1][0]), 32'h28);
    chk("R11 sticky", 32'(skid_ovf[1]), 1);
    // R9 squash from Running: no unblock
    @(negedge clk); idle_in(); cmt_squash[1] = 1; tick();
    chk("R9 no unblock from run", 32'(ren_unblock[1]), 0);
    chk("R9 zero credits", 32'(cred_disp[1]), 0);

    // R5 store meets full store queue on thread 0
    @(negedge clk); idle_in(); grp(0, 2, 3'd0, 3'd2, 8'h30, 8'h31); sq_full[0] = 1; tick();
    chk("R5 lanes", 32'(out_vld[0]), 1);
    chk("R5 block", 32'(ren_block[0]), 1);
    chk("R5 disp", 32'(cred_disp[0]), 1);
    @(negedge clk); idle_in(); sq_full[0] = 1; tick();
    chk("R5 still held", 32'(out_vld[0]), 0);
    chk("R7 no reblock", 32'(ren_block[0]), 0);
    @(negedge clk); idle_in(); tick();
    chk("R8 drain lane", 32'(out_vld[0]), 1);
    chk("R8 drain route", 32'(out_route[0][0]), 32'h11);
    chk("R8 drain tag", 32'(out_tag[0][0]), 32'h31);
    chk("R8 drain unblock", 32'(ren_unblock[0]), 1);
    chk("R3 drain sq", 32'(cred_sq[0]), 1);
    // R4 squashed-marked load in slot 0
    @(negedge clk); idle_in(); grp(0, 2, 3'd1, 3'd0, 8'h40, 8'h41); grp_squashed[0] = 1; tick();
    chk("R4 lanes", 32'(out_vld[0]), 2);
    chk("R4 lq credit", 32'(cred_lq[0]), 1);
    chk("R4 tag", 32'(out_tag[0][1]), 32'h41);

    @(negedge clk); idle_in(); tick();
    finish_run();
  end
endmodule